// File: doc/BRIEF.md
# Low-Power Wake-Up Controller

This block decides when a device parked in one of two low-power modes, stop or sleep, returns to normal operation. It watches two local switch inputs, a chip-select line, a LIN receive line and a slow timer tick. Only the sources that the configuration enables, latched when the mode is entered, can end a low-power episode.

The two modes report a wake-up in different ways. Leaving stop raises a one-cycle wake interrupt. Leaving sleep turns the regulator back on and holds the processor in reset for a fixed number of cycles. The switch inputs can be watched continuously (direct mode) or polled once per period (cyclic mode). In cyclic mode the high-side switch that powers the external contacts is turned on only near the end of each period. A forced mode instead ends the episode after a fixed time, with the switch kept off.

A sticky source register records which source caused the wake-up, and it is cleared by a read strobe. Chip-select wake-ups leave no trace in this register and raise no interrupt.

Top module: `wk_ctrl`

## Requirements
- R1: While reset is applied and for RST_CYCLES cycles after its release, `mode` reads 3, `mcu_rst` and `reg_en` are 1, and `isr` is 0. After that, `mode` reads 0 (normal).
- R2: In normal mode, `cmd_sleep` enters sleep (`mode`=2) and otherwise `cmd_stop` enters stop (`mode`=1), one cycle later. `reg_en` is 0 only in sleep. The configuration and the switch levels are latched on entry.
- R3: In direct mode, an enabled switch input whose level differs from its level at entry wakes the device one cycle later and sets `isr` bit 0 (input 0) or bit 1 (input 1). Changes on disabled inputs have no effect.
- R4: A source-driven wake from stop returns `mode` to 0 and pulses `wake_irq` for exactly one cycle.
- R5: A wake from sleep sets `mode`=3, `reg_en`=1 and `mcu_rst`=1 for RST_CYCLES cycles, then returns to normal. It raises no interrupt.
- R6: In cyclic mode a period lasts TICK_BASE<<`cfg_period` ticks. `hs_on` is 1 during the last HS_WIN ticks of each period. The enabled switch levels are compared with the entry levels only at the period end, and any difference wakes the device.
- R7: In forced mode the device wakes at the end of the first period, sets `isr` bit 3, and `hs_on` stays 0. If cyclic and forced are both requested, cyclic applies and forced is ignored.
- R8: A rising edge on `cs_n` wakes the device from stop without an interrupt and without any `isr` bit. In sleep, such an edge is ignored.
- R9: `lin_rx` (0 = dominant) held dominant for at least LIN_MIN cycles and then returned to recessive wakes the device and sets `isr` bit 2. A shorter pulse, or a line that stays dominant, does not.
- R10: With `cfg_rx_only` set at entry, LIN wake-up is disabled in stop but still works in sleep.
- R11: `isr` bits are sticky. An `isr_rd` pulse clears them on the next cycle; a bit that sets in the same cycle stays set.
- R12: `sw_stat` shows the level of `sw_in` one cycle after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Slow timebase pulse |
| cmd_stop | input | 1 | Enter stop mode |
| cmd_sleep | input | 1 | Enter sleep mode (wins over stop) |
| cfg_wake_en | input | 2 | Per-input switch wake enable |
| cfg_cyclic | input | 1 | Cyclic sensing select |
| cfg_forced | input | 1 | Forced timed wake select |
| cfg_period | input | 3 | Period code |
| cfg_rx_only | input | 1 | Receive-only: blocks LIN wake in stop |
| sw_in | input | 2 | Sampled local switch levels |
| cs_n | input | 1 | Chip select |
| lin_rx | input | 1 | LIN receive, 0 = dominant |
| isr_rd | input | 1 | Source register read strobe |
| hs_on | output | 1 | High-side switch enable |
| wake_irq | output | 1 | Wake interrupt pulse |
| reg_en | output | 1 | Regulator enable |
| mcu_rst | output | 1 | Processor reset request |
| mode | output | 2 | 0 normal, 1 stop, 2 sleep, 3 reset |
| isr | output | 4 | Source bits: 0/1 switch, 2 LIN, 3 timer |
| sw_stat | output | 2 | Switch level status |

## Verification
Every output comes from a register, so a stimulus that the clock edge sees changes `mode`, `wake_irq`, `isr` and `sw_stat` one cycle later. `hs_on` follows the tick count of the timer, and a reset pulse from sleep lasts RST_CYCLES cycles. The bench drives inputs and samples outputs on the falling edge. Each cycle it compares the outputs with a behavioural model that updates on the rising edge. Scenario checks then test fixed expected values at the cycle counts given above.

// File: rtl/wk_pkg.sv
`timescale 1ns/1ps
package wk_pkg;
    typedef enum logic [1:0] {
        MD_RUN   = 2'd0,
        MD_STOP  = 2'd1,
        MD_SLEEP = 2'd2,
        MD_RESET = 2'd3
    } wk_mode_e;

    typedef struct packed {
        logic [1:0] en;
        logic       cyc;
        logic       frc;
        logic [2:0] code;
        logic       rxo;
    } wk_cfg_t;

    localparam int unsigned SRC_W = 4;
endpackage

// File: rtl/wk_period_timer.sv
`timescale 1ns/1ps
module wk_period_timer #(
    parameter int unsigned BASE   = 4,
    parameter int unsigned HS_WIN = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       run,
    input  logic       cyc,
    input  logic       tick,
    input  logic [2:0] code,
    output logic       per_end,
    output logic       hs_win
);
    localparam int unsigned LEN_W = $clog2(BASE * 128 + 1);

    logic [LEN_W-1:0] cnt_d, cnt_q;
    logic [LEN_W-1:0] len;
    logic             at_end;

    assign len     = LEN_W'(BASE) << code;
    assign at_end  = (cnt_q == len - LEN_W'(1));
    assign per_end = run & tick & at_end;
    assign hs_win  = run & cyc & (cnt_q >= len - LEN_W'(HS_WIN));

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (run && tick)
            cnt_d = at_end ? '0 : cnt_q + LEN_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6: the sampling moment always falls inside the switch-on window
    a_r6_end_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (per_end && cyc) |-> hs_win);
endmodule

// File: rtl/wk_lin_qual.sv
`timescale 1ns/1ps
module wk_lin_qual #(
    parameter int unsigned LIN_MIN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lin_rx,
    output logic lin_ev
);
    localparam int unsigned DW = $clog2(LIN_MIN + 1);

    typedef struct packed {
        logic [DW-1:0] dom;
        logic          prev;
    } lq_t;

    lq_t s_d, s_q;

    assign lin_ev = lin_rx & ~s_q.prev & (s_q.dom >= DW'(LIN_MIN));

    always_comb begin
        s_d      = s_q;
        s_d.prev = lin_rx;
        if (lin_rx)
            s_d.dom = '0;
        else if (s_q.dom < DW'(LIN_MIN))
            s_d.dom = s_q.dom + DW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{dom: '0, prev: 1'b1};
        else        s_q <= s_d;
    end

    // R9: an event is only a recessive edge after a dominant level
    a_r9_edge_after_dominant: assert property (@(posedge clk) disable iff (!rst_n)
        lin_ev |-> (lin_rx && $past(!lin_rx)));
endmodule

// File: rtl/wk_ctrl.sv
`timescale 1ns/1ps
module wk_ctrl
    import wk_pkg::*;
#(
    parameter int unsigned TICK_BASE  = 4,
    parameter int unsigned HS_WIN     = 2,
    parameter int unsigned LIN_MIN    = 8,
    parameter int unsigned RST_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        cmd_stop,
    input  logic        cmd_sleep,
    input  logic [1:0]  cfg_wake_en,
    input  logic        cfg_cyclic,
    input  logic        cfg_forced,
    input  logic [2:0]  cfg_period,
    input  logic        cfg_rx_only,
    input  logic [1:0]  sw_in,
    input  logic        cs_n,
    input  logic        lin_rx,
    input  logic        isr_rd,
    output logic        hs_on,
    output logic        wake_irq,
    output logic        reg_en,
    output logic        mcu_rst,
    output logic [1:0]  mode,
    output logic [3:0]  isr,
    output logic [1:0]  sw_stat
);
    localparam int unsigned RC_W = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        wk_mode_e         mode;
        wk_cfg_t          cfg;
        logic [1:0]       sref;
        logic             cs_prev;
        logic [SRC_W-1:0] isr;
        logic             irq;
        logic [RC_W-1:0]  rcnt;
        logic [1:0]       swst;
    } st_t;

    st_t              s_d, s_q;
    logic             lp, entry, per_end, hs_win, lin_ev, cs_wake;
    logic             lin_src, tmr_src;
    logic [1:0]       sw_chg, sw_src;
    logic [SRC_W-1:0] src;

    wk_period_timer #(.BASE(TICK_BASE), .HS_WIN(HS_WIN)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (entry),
        .run    (lp & (s_q.cfg.cyc | s_q.cfg.frc)),
        .cyc    (s_q.cfg.cyc),
        .tick   (tick),
        .code   (s_q.cfg.code),
        .per_end(per_end),
        .hs_win (hs_win)
    );

    wk_lin_qual #(.LIN_MIN(LIN_MIN)) u_lin (
        .clk   (clk),
        .rst_n (rst_n),
        .lin_rx(lin_rx),
        .lin_ev(lin_ev)
    );

    assign lp = (s_q.mode == MD_STOP) || (s_q.mode == MD_SLEEP);

    always_comb begin
        s_d         = s_q;
        s_d.irq     = 1'b0;
        s_d.cs_prev = cs_n;
        s_d.swst    = sw_in;
        entry       = 1'b0;

        sw_chg  = (sw_in ^ s_q.sref) & s_q.cfg.en;
        sw_src  = s_q.cfg.cyc ? (per_end ? sw_chg : 2'b00) : sw_chg;
        lin_src = lin_ev & ~((s_q.mode == MD_STOP) & s_q.cfg.rxo);
        tmr_src = per_end & s_q.cfg.frc;
        src     = lp ? {tmr_src, lin_src, sw_src} : '0;
        cs_wake = (s_q.mode == MD_STOP) & cs_n & ~s_q.cs_prev;

        s_d.isr = (isr_rd ? '0 : s_q.isr) | src;

        case (s_q.mode)
            MD_RESET: begin
                s_d.rcnt = s_q.rcnt + RC_W'(1);
                if (s_q.rcnt == RC_W'(RST_CYCLES - 1))
                    s_d.mode = MD_RUN;
            end
            MD_RUN: begin
                if (cmd_sleep || cmd_stop) begin
                    entry        = 1'b1;
                    s_d.mode     = cmd_sleep ? MD_SLEEP : MD_STOP;
                    s_d.cfg.en   = cfg_wake_en;
                    s_d.cfg.cyc  = cfg_cyclic;
                    s_d.cfg.frc  = cfg_forced & ~cfg_cyclic;
                    s_d.cfg.code = cfg_period;
                    s_d.cfg.rxo  = cfg_rx_only;
                    s_d.sref     = sw_in;
                end
            end
            MD_STOP: begin
                if ((|src) || cs_wake) begin
                    s_d.mode = MD_RUN;
                    s_d.irq  = |src;
                end
            end
            default: begin
                if (|src) begin
                    s_d.mode = MD_RESET;
                    s_d.rcnt = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.mode    <= MD_RESET;
            s_q.cs_prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign hs_on    = hs_win;
    assign wake_irq = s_q.irq;
    assign reg_en   = (s_q.mode != MD_SLEEP);
    assign mcu_rst  = (s_q.mode == MD_RESET);
    assign mode     = s_q.mode;
    assign isr      = s_q.isr;
    assign sw_stat  = s_q.swst;

    // R4: interrupt lasts one cycle
    a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |=> !wake_irq);
    // R4: interrupt only on the way out of stop
    a_r4_irq_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |-> (s_q.mode == MD_RUN && $past(s_q.mode) == MD_STOP));
    // R11: a read with nothing new leaves the register empty
    a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd && src == '0) |=> (isr == '0));
    // R7: timed wake keeps the switch dark
    a_r7_forced_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (lp && s_q.cfg.frc) |-> !hs_on);
    // R8: chip-select wake is silent
    a_r8_cs_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_wake && src == '0) |=> !wake_irq);
    // R5: reset pulse ends into normal mode
    a_r5_reset_end: assert property (@(posedge clk) disable iff (!rst_n)
        (mcu_rst && s_q.rcnt == RC_W'(RST_CYCLES - 1)) |=> (mode == 2'd0));
endmodule

// File: tb/tb_wk_ctrl.sv
`timescale 1ns/1ps
module tb_wk_ctrl;
    localparam int BASE = 4, HSW = 2, LMIN = 8, RSTC = 16;

    logic clk = 0, rst_n = 0, tick = 0;
    logic cmd_stop = 0, cmd_sleep = 0;
    logic [1:0] cfg_wake_en = 0;
    logic cfg_cyclic = 0, cfg_forced = 0, cfg_rx_only = 0;
    logic [2:0] cfg_period = 0;
    logic [1:0] sw_in = 0;
    logic cs_n = 1, lin_rx = 1, isr_rd = 0;
    logic hs_on, wake_irq, reg_en, mcu_rst;
    logic [1:0] mode, sw_stat;
    logic [3:0] isr;

    int n_chk = 0, n_fail = 0, cyc_cnt = 0, tdiv = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wk_ctrl #(.TICK_BASE(BASE), .HS_WIN(HSW), .LIN_MIN(LMIN), .RST_CYCLES(RSTC)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_stop(cmd_stop), .cmd_sleep(cmd_sleep),
        .cfg_wake_en(cfg_wake_en), .cfg_cyclic(cfg_cyclic), .cfg_forced(cfg_forced),
        .cfg_period(cfg_period), .cfg_rx_only(cfg_rx_only), .sw_in(sw_in), .cs_n(cs_n),
        .lin_rx(lin_rx), .isr_rd(isr_rd), .hs_on(hs_on), .wake_irq(wake_irq),
        .reg_en(reg_en), .mcu_rst(mcu_rst), .mode(mode), .isr(isr), .sw_stat(sw_stat));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference
    int m_mode, m_rc, m_code, m_tc, m_dom, m_len;
    logic [1:0] m_en, m_ref, m_sw, sws, chg;
    logic m_cyc, m_frc, m_rxo, m_csp, m_irq, m_lp, lp, pend, linev, lins, tms, csw;
    logic [3:0] m_isr, src;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 3; m_rc = 0; m_en = 0; m_cyc = 0; m_frc = 0; m_code = 0; m_rxo = 0;
            m_ref = 0; m_csp = 1; m_isr = 0; m_irq = 0; m_sw = 0; m_tc = 0; m_lp = 1; m_dom = 0;
        end else begin
            m_len = BASE << m_code;
            lp    = (m_mode == 1 || m_mode == 2);
            pend  = lp && (m_cyc || m_frc) && tick && (m_tc == m_len - 1);
            linev = lin_rx && !m_lp && (m_dom >= LMIN);
            chg   = (sw_in ^ m_ref) & m_en;
            sws   = m_cyc ? (pend ? chg : 2'b00) : chg;
            lins  = linev && !(m_mode == 1 && m_rxo);
            tms   = pend && m_frc;
            src   = lp ? {tms, lins, sws} : 4'b0;
            csw   = (m_mode == 1) && cs_n && !m_csp;
            if (m_mode == 0 && (cmd_stop || cmd_sleep)) m_tc = 0;
            else if (lp && (m_cyc || m_frc) && tick) m_tc = (m_tc == m_len - 1) ? 0 : m_tc + 1;
            if (lin_rx) m_dom = 0; else if (m_dom < LMIN) m_dom++;
            m_lp  = lin_rx;
            m_isr = (isr_rd ? 4'b0 : m_isr) | src;
            m_irq = 0; m_csp = cs_n; m_sw = sw_in;
            case (m_mode)
                3: begin if (m_rc == RSTC - 1) m_mode = 0; m_rc++; end
                0: if (cmd_stop || cmd_sleep) begin
                       m_mode = cmd_sleep ? 2 : 1;
                       m_en = cfg_wake_en; m_cyc = cfg_cyclic; m_frc = cfg_forced && !cfg_cyclic;
                       m_code = cfg_period; m_rxo = cfg_rx_only; m_ref = sw_in;
                   end
                1: if (src != 0 || csw) begin m_mode = 0; m_irq = (src != 0); end
                default: if (src != 0) begin m_mode = 3; m_rc = 0; end
            endcase
        end
    end

    always @(negedge clk) begin
        int len, exp_hs;
        len = BASE << m_code;
        exp_hs = ((m_mode == 1 || m_mode == 2) && m_cyc && m_tc >= len - HSW) ? 1 : 0;
        chk(mode == 2'(m_mode), "R2 mode", mode, m_mode);
        chk(wake_irq == m_irq, "R4 wake_irq", wake_irq, m_irq);
        chk(isr == m_isr, "R11 isr", isr, m_isr);
        chk(hs_on == 1'(exp_hs), "R6 hs_on", hs_on, exp_hs);
        chk(reg_en == (m_mode != 2), "R5 reg_en", reg_en, m_mode != 2);
        chk(mcu_rst == (m_mode == 3), "R1 mcu_rst", mcu_rst, m_mode == 3);
        chk(sw_stat == m_sw, "R12 sw_stat", sw_stat, m_sw);
    end

    always @(negedge clk) begin
        tick = (tdiv == 3);
        tdiv = (tdiv + 1) % 4;
    end

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 20000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 20000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic enter(input bit slp);
        if (slp) cmd_sleep = 1; else cmd_stop = 1;
        cycles(1);
        cmd_sleep = 0; cmd_stop = 0;
    endtask

    task automatic cs_edge();
        cs_n = 0; cycles(1); cs_n = 1; cycles(1);
    endtask

    task automatic lin_pulse(input int n);
        lin_rx = 0; cycles(n); lin_rx = 1; cycles(1);
    endtask

    task automatic clear_isr();
        isr_rd = 1; cycles(1); isr_rd = 0; cycles(1);
    endtask

    initial begin
        cycles(3);
        chk(mode == 2'd3 && mcu_rst && isr == 0, "R1 reset state", mode, 3);
        rst_n = 1;
        cycles(RSTC - 1);
        chk(mode == 2'd3, "R1 still in reset", mode, 3);
        cycles(2);
        chk(mode == 2'd0 && !mcu_rst, "R1 released", mode, 0);

        sw_in = 2'b10; cycles(1);
        chk(sw_stat == 2'b10, "R12 status", sw_stat, 2);

        // direct wake from stop
        cfg_wake_en = 2'b01; enter(0);
        chk(mode == 2'd1, "R2 stop entered", mode, 1);
        sw_in = 2'b00; cycles(3);
        chk(mode == 2'd1 && isr == 0, "R3 disabled input ignored", mode, 1);
        sw_in = 2'b01; cycles(1);
        chk(mode == 2'd0 && isr[0], "R3 enabled input wakes", isr, 1);
        chk(wake_irq == 1, "R4 interrupt pulse", wake_irq, 1);
        cycles(1);
        chk(wake_irq == 0, "R4 pulse ends", wake_irq, 0);
        clear_isr();
        chk(isr == 0, "R11 read clears", isr, 0);

        // direct wake from sleep
        enter(1);
        chk(mode == 2'd2 && !reg_en, "R2 sleep entered", reg_en, 0);
        sw_in = 2'b00; cycles(1);
        chk(mode == 2'd3 && mcu_rst && reg_en && !wake_irq, "R5 sleep wake resets", mode, 3);
        cycles(RSTC + 1);
        chk(mode == 2'd0, "R5 back to normal", mode, 0);
        clear_isr();

        // cyclic sensing
        cfg_wake_en = 2'b11; cfg_cyclic = 1; cfg_period = 0; enter(0);
        cycles(20);
        sw_in = 2'b10; cycles(1);
        chk(mode == 2'd1, "R6 no immediate wake", mode, 1);
        cycles(40);
        chk(mode == 2'd0 && isr[1], "R6 wake at period end", isr, 2);
        clear_isr();

        // exclusivity, then chip-select exit
        cfg_wake_en = 2'b00; cfg_forced = 1; enter(0);
        cycles(60);
        chk(mode == 2'd1 && isr == 0, "R7 forced ignored under cyclic", mode, 1);
        cs_edge();
        chk(mode == 2'd0 && isr == 0, "R8 cs wake silent", mode, 0);

        // forced wake
        cfg_cyclic = 0; cfg_period = 1; enter(0);
        cycles(45);
        chk(mode == 2'd0 && isr[3], "R7 forced wake", isr, 8);
        clear_isr();
        cfg_forced = 0;

        // sleep: cs ignored, LIN qualification
        enter(1);
        cs_edge(); cycles(2);
        chk(mode == 2'd2, "R8 cs ignored in sleep", mode, 2);
        lin_pulse(3); cycles(1);
        chk(mode == 2'd2, "R9 short pulse ignored", mode, 2);
        lin_rx = 0; cycles(30);
        chk(mode == 2'd2, "R9 stuck dominant ignored", mode, 2);
        lin_rx = 1; cycles(1);
        chk(mode == 2'd3 && isr[2], "R9 LIN wake", isr, 4);
        cycles(RSTC + 1);
        clear_isr();

        // receive-only
        cfg_rx_only = 1; enter(0);
        lin_pulse(10); cycles(1);
        chk(mode == 2'd1 && isr == 0, "R10 LIN blocked in stop", mode, 1);
        cs_edge();
        enter(1);
        lin_pulse(10);
        chk(mode == 2'd3, "R10 LIN works in sleep", mode, 3);
        cycles(RSTC + 2);
        chk(mode == 2'd0, "R5 final normal", mode, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule